// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Invalidation Decoder

This block is the translation cache that sits in front of a device address translator. Each line remembers one 4 KiB page mapping: a 7-bit address-space tag, the 20-bit virtual page number (VA[31:12]), a physical frame number, and three permission flags (readable, writable, non-secure). A client presents an address-space tag and a 32-bit virtual address and learns in the same cycle whether the mapping is cached. On a hit it also gets the physical address and the permissions. On a miss, the table walker outside the block returns the entry through a refill port.

A single 32-bit invalidation word clears lines. It can clear every address, a 4 MiB section or a 16 KiB group, and it can optionally be restricted to one address-space tag. Configuration inputs provide a global enable, a limit on how many lines take part, and a switch that lets hits proceed while a refill is still outstanding. Refills go first to a free line. When no line is free, they replace lines in round-robin order.

Top module: `asid_tlb`

## Requirements
- R1: After reset every line is invalid and no refill is outstanding, so the first enabled lookup reports `lk_miss` and not `lk_hit`.
- R2: A lookup hits when an active valid line holds the same tag and VA[31:12]. `lk_pa` is then {PFN, VA[11:0]}, and `lk_perm` is the stored {readable, writable, non-secure} in bits 2, 1, 0.
- R3: Exactly one of `lk_hit`, `lk_miss` and `lk_stall` is high for an enabled lookup. A miss marks a refill outstanding from the next cycle. An accepted `rf_valid` clears that mark.
- R4: While a refill is outstanding, no lookup reports `lk_miss`. A lookup that would hit reports `lk_hit` only when `cfg_hit_under_miss` is 1. Every other lookup reports `lk_stall`.
- R5: Invalidation bits 1:0 pick the address match. Value 0 matches all addresses. Value 2 matches lines whose VA[31:22] equals bits 19:10. Value 3 matches lines whose VA[31:14] equals bits 19:2. Value 1 clears nothing.
- R6: Invalidation bit 31 restricts the match to lines whose tag equals bits 30:24. With bit 31 clear, lines of every tag are candidates.
- R7: An invalidation takes effect at the next clock edge, so a lookup in the same cycle still sees the old contents. A refill in that same cycle is installed after the clearing and survives it.
- R8: Only lines below min(`cfg_active_lines`, N_LINES) can hit or be filled. A refill while the count is 0 is dropped.
- R9: A refill goes to the lowest-numbered invalid active line. If every active line is valid, it goes to a round-robin pointer. The pointer starts at line 0, advances past each line it replaces, and wraps at the active count.
- R10: With `cfg_enable` at 0, `lk_hit`, `lk_miss` and `lk_stall` stay 0, and no refill becomes outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Global translation enable |
| cfg_active_lines | input | IDXW+1 | Number of lines that take part |
| cfg_hit_under_miss | input | 1 | Let hits complete while a refill is outstanding |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 7 | Lookup address-space tag |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup miss, refill needed |
| lk_stall | output | 1 | Lookup held back by an outstanding refill |
| lk_pa | output | PFN_W+12 | Physical address on hit |
| lk_perm | output | 3 | Permissions on hit {rd, wr, ns} |
| rf_valid | input | 1 | Refill entry present |
| rf_asid | input | 7 | Refill tag |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_pfn | input | PFN_W | Refill frame number |
| rf_perm | input | 3 | Refill permissions {rd, wr, ns} |
| fl_valid | input | 1 | Invalidation command present |
| fl_cmd | input | 32 | Invalidation command word |

## Verification
The bench builds the block with N_LINES = 4 and PFN_W = 20. With only four lines, every fill in the test drives the victim choice through both the free-line and round-robin paths, and the round-robin pointer wraps. After each fill or invalidation, a sweep probes every stored tag and page along with their near neighbours, so section, group, tag-restricted and reserved invalidations are all compared against an arithmetic model. Active-line counts of 0, 1, 2 and 4 are also exercised.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  localparam int ASID_W  = 7;
  localparam int VPN_W   = 20;
  localparam int OFS_W   = 12;
  localparam int SECT_W  = 10;   // VA[31:22]
  localparam int GRP_W   = 18;   // VA[31:14]
  localparam int CMD_W   = 32;
  localparam int ASID_EN_BIT = 31;
  localparam int ASID_LSB    = 24;
  localparam int SECT_LSB    = 10;
  localparam int GRP_LSB     = 2;

  typedef enum logic [1:0] {
    FL_ALL     = 2'd0,
    FL_RSVD    = 2'd1,
    FL_SECTION = 2'd2,
    FL_GROUP   = 2'd3
  } fl_mode_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ns;
  } perm_t;

  typedef struct packed {
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
  } tag_t;

  typedef struct packed {
    logic              active;
    logic              asid_en;
    logic [ASID_W-1:0] asid;
    fl_mode_e          mode;
    logic [SECT_W-1:0] sect;
    logic [GRP_W-1:0]  grp;
  } flush_t;
endpackage

// File: rtl/asid_tlb_flush_dec.sv
module asid_tlb_flush_dec
  import asid_tlb_pkg::*;
(
  input  logic             fl_valid,
  input  logic [CMD_W-1:0] fl_cmd,
  output flush_t           req
);
  logic [3:0] unused_cmd_bits;

  always_comb begin
    req.active  = fl_valid;
    req.asid_en = fl_cmd[ASID_EN_BIT];
    req.asid    = fl_cmd[ASID_LSB +: ASID_W];
    req.mode    = fl_mode_e'(fl_cmd[1:0]);
    req.sect    = fl_cmd[SECT_LSB +: SECT_W];
    req.grp     = fl_cmd[GRP_LSB +: GRP_W];
  end

  assign unused_cmd_bits = fl_cmd[23:20];
endmodule

// File: rtl/asid_tlb_line.sv
module asid_tlb_line
  import asid_tlb_pkg::*;
#(
  parameter int PFN_W = 20
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_active,
  input  tag_t             lk_tag,
  input  flush_t           flush,
  input  logic             fill_en,
  input  tag_t             fill_tag,
  input  logic [PFN_W-1:0] fill_pfn,
  input  perm_t            fill_perm,
  output logic             lk_match,
  output logic             valid_o,
  output logic [PFN_W-1:0] pfn_o,
  output perm_t            perm_o
);
  logic             valid_q, valid_d;
  tag_t             tag_q;
  logic [PFN_W-1:0] pfn_q;
  perm_t            perm_q;
  logic             asid_ok, addr_ok, kill;

  always_comb begin
    asid_ok = !flush.asid_en || (tag_q.asid == flush.asid);
    unique case (flush.mode)
      FL_ALL:     addr_ok = 1'b1;
      FL_SECTION: addr_ok = (tag_q.vpn[VPN_W-1 -: SECT_W] == flush.sect);
      FL_GROUP:   addr_ok = (tag_q.vpn[VPN_W-1 -: GRP_W] == flush.grp);
      default:    addr_ok = 1'b0;
    endcase
    kill = flush.active && asid_ok && addr_ok;

    valid_d = valid_q;
    if (kill)    valid_d = 1'b0;
    if (fill_en) valid_d = 1'b1;   // refill lands after the invalidation
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q  <= fill_tag;
      pfn_q  <= fill_pfn;
      perm_q <= fill_perm;
    end
  end

  assign lk_match = valid_q && line_active && (tag_q == lk_tag);
  assign valid_o  = valid_q;
  assign pfn_o    = pfn_q;
  assign perm_o   = perm_q;
endmodule

// File: rtl/asid_tlb_victim.sv
module asid_tlb_victim #(
  parameter int N_LINES = 8,
  localparam int IDXW = $clog2(N_LINES)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_LINES-1:0] line_valid,
  input  logic [N_LINES-1:0] act_mask,
  input  logic [IDXW:0]     act_cnt,
  input  logic              fill_take,
  output logic [IDXW-1:0]   victim
);
  logic [IDXW-1:0] ptr_q, ptr_d;
  logic            free_found;
  logic [IDXW:0]   next_idx;

  always_comb begin
    free_found = 1'b0;
    victim     = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (!free_found && act_mask[i] && !line_valid[i]) begin
        free_found = 1'b1;
        victim     = IDXW'(i);
      end
    end
    if (!free_found)
      victim = ({1'b0, ptr_q} < act_cnt) ? ptr_q : '0;

    next_idx = {1'b0, victim} + 1'b1;
    ptr_d    = ptr_q;
    if (fill_take && !free_found)
      ptr_d = (next_idx >= act_cnt) ? '0 : next_idx[IDXW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int PFN_W   = 20,
  localparam int IDXW   = $clog2(N_LINES),
  localparam int PA_W   = PFN_W + OFS_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [IDXW:0]     cfg_active_lines,
  input  logic              cfg_hit_under_miss,
  input  logic              lk_valid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [31:0]       lk_va,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_stall,
  output logic [PA_W-1:0]   lk_pa,
  output logic [2:0]        lk_perm,
  input  logic              rf_valid,
  input  logic [ASID_W-1:0] rf_asid,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [PFN_W-1:0]  rf_pfn,
  input  logic [2:0]        rf_perm,
  input  logic              fl_valid,
  input  logic [CMD_W-1:0]  fl_cmd
);
  flush_t             flush_req;
  tag_t               lk_tag, fill_tag;
  logic [IDXW:0]      act_cnt;
  logic [N_LINES-1:0] act_mask, hit_vec, line_valid, fill_vec;
  logic [PFN_W-1:0]   line_pfn [N_LINES];
  perm_t              line_perm [N_LINES];
  logic [IDXW-1:0]    victim;
  logic               fill_take, any_hit, pend_q, pend_d;
  logic [PFN_W-1:0]   pfn_sel;
  perm_t              perm_sel;

  asid_tlb_flush_dec i_dec (
    .fl_valid (fl_valid),
    .fl_cmd   (fl_cmd),
    .req      (flush_req)
  );

  always_comb begin
    act_cnt = (cfg_active_lines > (IDXW+1)'(N_LINES)) ? (IDXW+1)'(N_LINES)
                                                      : cfg_active_lines;
    for (int i = 0; i < N_LINES; i++)
      act_mask[i] = ((IDXW+1)'(i) < act_cnt);
  end

  assign lk_tag    = '{asid: lk_asid, vpn: lk_va[31:OFS_W]};
  assign fill_tag  = '{asid: rf_asid, vpn: rf_vpn};
  assign fill_take = rf_valid && (act_cnt != '0);

  asid_tlb_victim #(.N_LINES(N_LINES)) i_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_valid (line_valid),
    .act_mask   (act_mask),
    .act_cnt    (act_cnt),
    .fill_take  (fill_take),
    .victim     (victim)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    assign fill_vec[g] = fill_take && (victim == IDXW'(g));

    asid_tlb_line #(.PFN_W(PFN_W)) i_line (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_active (act_mask[g]),
      .lk_tag      (lk_tag),
      .flush       (flush_req),
      .fill_en     (fill_vec[g]),
      .fill_tag    (fill_tag),
      .fill_pfn    (rf_pfn),
      .fill_perm   (perm_t'(rf_perm)),
      .lk_match    (hit_vec[g]),
      .valid_o     (line_valid[g]),
      .pfn_o       (line_pfn[g]),
      .perm_o      (line_perm[g])
    );
  end

  always_comb begin
    pfn_sel  = '0;
    perm_sel = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (hit_vec[i]) begin
        pfn_sel  = pfn_sel | line_pfn[i];
        perm_sel = perm_sel | line_perm[i];
      end
    end
  end

  assign any_hit  = |hit_vec;
  assign lk_hit   = cfg_enable && lk_valid && any_hit && (!pend_q || cfg_hit_under_miss);
  assign lk_miss  = cfg_enable && lk_valid && !pend_q && !any_hit;
  assign lk_stall = cfg_enable && lk_valid && pend_q && !(any_hit && cfg_hit_under_miss);
  assign lk_pa    = {pfn_sel, lk_va[OFS_W-1:0]};
  assign lk_perm  = perm_sel;

  always_comb begin
    pend_d = pend_q;
    if (rf_valid) pend_d = 1'b0;
    if (lk_miss)  pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int N_LINES = 8,
  parameter int PA_W    = 32,
  localparam int IDXW   = $clog2(N_LINES)
)(
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_enable,
  input logic [IDXW:0]      cfg_active_lines,
  input logic               cfg_hit_under_miss,
  input logic [31:0]        lk_va,
  input logic               lk_hit,
  input logic               lk_miss,
  input logic               lk_stall,
  input logic [PA_W-1:0]    lk_pa,
  input logic               rf_valid,
  input logic               fl_valid,
  input logic [31:0]        fl_cmd,
  input logic [N_LINES-1:0] line_valid,
  input logic               miss_pend
);
  assert_single_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_miss, lk_stall}));

  assert_miss_marks_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |=> miss_pend);

  assert_stall_only_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_stall |-> miss_pend);

  assert_hit_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_pend && !cfg_hit_under_miss) |-> !lk_hit);

  assert_page_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_pa[11:0] == lk_va[11:0]));

  assert_flush_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && fl_cmd == 32'h0 && !rf_valid) |=> (line_valid == '0));

  assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> !(lk_hit || lk_miss || lk_stall));

  assert_no_fill_inactive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && !fl_valid && cfg_active_lines == '0) |=> $stable(line_valid));
endmodule

bind asid_tlb asid_tlb_chk #(.N_LINES(N_LINES), .PA_W(PA_W)) i_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .cfg_enable         (cfg_enable),
  .cfg_active_lines   (cfg_active_lines),
  .cfg_hit_under_miss (cfg_hit_under_miss),
  .lk_va              (lk_va),
  .lk_hit             (lk_hit),
  .lk_miss            (lk_miss),
  .lk_stall           (lk_stall),
  .lk_pa              (lk_pa),
  .rf_valid           (rf_valid),
  .fl_valid           (fl_valid),
  .fl_cmd             (fl_cmd),
  .line_valid         (line_valid),
  .miss_pend          (pend_q)
);

// File: tb/test_asid_tlb.sv
`timescale 1ns/1ps
module test_asid_tlb;
  localparam int NL   = 4;
  localparam int IDXW = $clog2(NL);

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_enable, cfg_hum;
  logic [IDXW:0] cfg_act;
  logic lk_valid, rf_valid, fl_valid;
  logic [6:0] lk_asid, rf_asid;
  logic [31:0] lk_va, fl_cmd;
  logic [19:0] rf_vpn, rf_pfn;
  logic [2:0] rf_perm, lk_perm;
  logic lk_hit, lk_miss, lk_stall;
  logic [31:0] lk_pa;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit         m_v    [NL];
  logic [6:0]  m_asid [NL];
  logic [19:0] m_vpn  [NL];
  logic [19:0] m_pfn  [NL];
  logic [2:0]  m_perm [NL];
  int m_ptr;
  bit m_pend;

  always #2.5 clk = ~clk;

  asid_tlb #(.N_LINES(NL), .PFN_W(20)) i_asid_tlb (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_active_lines(cfg_act),
    .cfg_hit_under_miss(cfg_hum), .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_va(lk_va),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_stall(lk_stall), .lk_pa(lk_pa), .lk_perm(lk_perm),
    .rf_valid(rf_valid), .rf_asid(rf_asid), .rf_vpn(rf_vpn), .rf_pfn(rf_pfn), .rf_perm(rf_perm),
    .fl_valid(fl_valid), .fl_cmd(fl_cmd)
  );

  task automatic check(input bit ok, input string req, input logic [37:0] got, input logic [37:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic int model_act();
    return (int'(cfg_act) > NL) ? NL : int'(cfg_act);
  endfunction

  function automatic bit fl_match(int i, logic [31:0] c);
    bit a_ok, v_ok;
    a_ok = !c[31] || (m_asid[i] == c[30:24]);
    case (c[1:0])
      2'd0: v_ok = 1;
      2'd2: v_ok = (m_vpn[i][19:10] == c[19:10]);
      2'd3: v_ok = (m_vpn[i][19:2] == c[19:2]);
      default: v_ok = 0;
    endcase
    return a_ok && v_ok;
  endfunction

  task automatic step(input bit lk, input logic [6:0] la, input logic [31:0] lva,
                      input bit rf, input logic [6:0] ra, input logic [19:0] rvpn,
                      input logic [19:0] rpfn, input logic [2:0] rperm,
                      input bit fl, input logic [31:0] cmd, input bit do_chk, input string req);
    int act, hidx, hs, vic;
    bit eh, em, es, found;
    logic [37:0] got, exp;
    lk_valid = lk; lk_asid = la; lk_va = lva;
    rf_valid = rf; rf_asid = ra; rf_vpn = rvpn; rf_pfn = rpfn; rf_perm = rperm;
    fl_valid = fl; fl_cmd = cmd;
    #1;
    act = model_act();
    hidx = -1;
    for (int i = 0; i < act; i++)
      if (hidx < 0 && m_v[i] && m_asid[i] == la && m_vpn[i] == lva[31:12]) hidx = i;
    hs = (hidx < 0) ? 0 : hidx;
    eh = 0; em = 0; es = 0;
    if (cfg_enable && lk) begin
      if (m_pend) begin
        if (hidx >= 0 && cfg_hum) eh = 1; else es = 1;
      end else if (hidx >= 0) eh = 1;
      else em = 1;
    end
    exp = {eh, em, es, eh ? {m_pfn[hs], lva[11:0]} : 32'h0, eh ? m_perm[hs] : 3'b0};
    got = {lk_hit, lk_miss, lk_stall, lk_hit ? lk_pa : 32'h0, lk_hit ? lk_perm : 3'b0};
    if (do_chk) check(got === exp, req, got, exp);
    @(posedge clk);
    vic = 0; found = 0;
    if (rf && act > 0) begin
      for (int i = 0; i < act; i++)
        if (!found && !m_v[i]) begin found = 1; vic = i; end
      if (!found) begin
        vic = (m_ptr < act) ? m_ptr : 0;
        m_ptr = (vic + 1 >= act) ? 0 : vic + 1;
      end
    end
    if (fl) for (int i = 0; i < NL; i++) if (fl_match(i, cmd)) m_v[i] = 0;
    if (rf && act > 0) begin
      m_v[vic] = 1; m_asid[vic] = ra; m_vpn[vic] = rvpn; m_pfn[vic] = rpfn; m_perm[vic] = rperm;
    end
    if (em) m_pend = 1; else if (rf) m_pend = 0;
    @(negedge clk);
    lk_valid = 0; rf_valid = 0; fl_valid = 0;
  endtask

  task automatic look(input logic [6:0] a, input logic [31:0] va, input string req);
    step(1, a, va, 0, 0, 0, 0, 0, 0, 0, 1, req);
  endtask
  task automatic fill(input logic [6:0] a, input logic [19:0] vpn, input logic [19:0] pfn, input logic [2:0] p);
    step(0, 0, 0, 1, a, vpn, pfn, p, 0, 0, 0, "");
  endtask
  task automatic flush(input logic [31:0] c);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, c, 0, "");
  endtask

  task automatic sweep(input string req);
    logic [6:0] a;
    logic [19:0] v;
    for (int i = 0; i < NL; i++) begin
      a = m_asid[i]; v = m_vpn[i];
      look(a, {v, 12'h5a4 + 12'(i)}, req);
      look(a ^ 7'h01, {v, 12'h010}, req);
      look(a, {v ^ 20'h00004, 12'h0ff}, req);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_enable = 1; cfg_hum = 1; cfg_act = 3'(NL);
    lk_valid = 0; lk_asid = 0; lk_va = 0; rf_valid = 0; rf_asid = 0; rf_vpn = 0;
    rf_pfn = 0; rf_perm = 0; fl_valid = 0; fl_cmd = 0;
    for (int i = 0; i < NL; i++) begin
      m_v[i] = 0; m_asid[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0; m_perm[i] = 0;
    end
    m_ptr = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state, idle outputs then a cold miss
    #1;
    check({lk_hit, lk_miss, lk_stall} === 3'b000, "R1 idle",
          {35'h0, lk_hit, lk_miss, lk_stall}, 38'h0);
    @(negedge clk);
    look(7'd5, 32'h1234_5678, "R1 cold miss");
    look(7'd5, 32'h1234_5678, "R4 stall while pending");

    // R2 R9: fill the four lines, sweep with hit under miss enabled
    fill(7'd1, 20'h10000, 20'hA0001, 3'b111);
    fill(7'd2, 20'h10401, 20'hA0002, 3'b100);
    fill(7'd3, 20'h20802, 20'hA0003, 3'b010);
    fill(7'd1, 20'h20C07, 20'hA0004, 3'b001);
    sweep("R2 lookup sweep");

    // R9: round robin once full, then wrap
    fill(7'd4, 20'h30000, 20'hB0001, 3'b110);
    fill(7'd4, 20'h30001, 20'hB0002, 3'b101);
    sweep("R9 round robin");

    // R5: group invalidation then free line reuse (R9)
    flush({12'h0, m_vpn[2][19:2], 2'd3});
    sweep("R5 group flush");
    fill(7'd6, 20'h40000, 20'hC0001, 3'b011);
    sweep("R9 free line first");

    // R5: reserved mode leaves all lines
    flush({12'h0, m_vpn[0][19:2], 2'd1});
    sweep("R5 reserved mode");

    // R5 R6: section with and without tag qualifier
    flush({1'b1, 7'd9, 4'h0, 10'h0C0, 8'h0, 2'd2});
    sweep("R6 section wrong tag");
    flush({1'b0, 7'd0, 4'h0, 10'h0C0, 8'h0, 2'd2});
    sweep("R5 section any tag");

    // R6: whole address space of one tag
    fill(7'd1, 20'h50010, 20'hD0001, 3'b111);
    fill(7'd1, 20'h60020, 20'hD0002, 3'b111);
    flush({1'b1, 7'd1, 24'h0});
    sweep("R6 tag flush");

    // R7: lookup in the invalidation cycle sees old contents
    fill(7'd7, 20'h70000, 20'hE0001, 3'b100);
    step(1, 7'd7, 32'h7000_0123, 0, 0, 0, 0, 0, 1, 32'h0, 1, "R7 same cycle old state");
    look(7'd7, 32'h7000_0123, "R7 after flush");
    // R7: refill with a global invalidation survives
    step(0, 0, 0, 1, 7'd8, 20'h80000, 20'hE0002, 3'b010, 1, 32'h0, 0, "");
    look(7'd8, 32'h8000_0abc, "R7 fill survives flush");
    sweep("R7 sweep");

    // R4: hit under miss disabled gives stall
    look(7'd8, 32'h8000_0abc, "R4 hum on hit");
    cfg_hum = 0;
    look(7'd8, 32'h8000_0abc, "R4 hum off stall");
    look(7'd2, 32'h9999_9000, "R4 miss while pending");
    fill(7'd9, 20'h90000, 20'hE0003, 3'b001);
    look(7'd8, 32'h8000_0abc, "R3 pending cleared");
    look(7'd2, 32'h9999_9000, "R3 new miss");
    fill(7'd2, 20'h99999, 20'hE0004, 3'b110);
    cfg_hum = 1;

    // R8: active line limit
    flush(32'h0);
    cfg_act = 3'd2;
    fill(7'd10, 20'hA0000, 20'h11111, 3'b111);
    fill(7'd11, 20'hA0001, 20'h22222, 3'b111);
    fill(7'd12, 20'hA0002, 20'h33333, 3'b111);
    sweep("R8 two lines");
    cfg_act = 3'd4;
    fill(7'd13, 20'hA0003, 20'h44444, 3'b101);
    cfg_act = 3'd1;
    sweep("R8 one line");
    cfg_act = 3'd0;
    fill(7'd14, 20'hA0004, 20'h55555, 3'b111);
    cfg_act = 3'd4;
    look(7'd14, 32'hA000_4000, "R8 zero count drops fill");
    sweep("R8 restored");

    // R10: disabled block is silent and does not mark pending
    cfg_enable = 0;
    look(7'd13, 32'hA000_3000, "R10 off hit");
    look(7'd50, 32'hFFFF_F000, "R10 off miss");
    cfg_enable = 1;
    look(7'd13, 32'hA000_3000, "R10 back on");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule